// File: doc/BRIEF.md
# Battery Backup Switchover Controller

This block decides, once per clock, whether the protected output rail should be fed from the main supply or from the backup battery. It receives both voltages as digitised codes with 1 mV per LSB and compares them with two different margins. The rail moves to the battery when the supply's lead over the battery drops below a small margin. It moves back to the supply only when that lead reaches a larger margin. The gap between the two margins is a hysteresis band that stops rapid toggling when the supply sits near the battery voltage.

The chosen source is held in a single registered bit. That bit drives the battery-on status output and a backup-mode flag. While in backup, the block forces the system status outputs to safe levels. The gated chip-enable of the battery-backed memory is held inactive, so writes are blocked. The power-fail warning output is held low, whatever the comparator reports. Outside backup, the gated chip-enable also goes inactive whenever the supply-low flag from the reset comparator is raised. All analog measurement and the power switches themselves sit outside this block.

Top module: `batt_switchover_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the source register returns to supply mode, so `batt_on` and `backup_mode` read 0 after that edge.
- R2: In battery mode, if `supply_code >= batt_code + RISE_MV` (default 70) at a rising edge, supply mode takes effect after that edge. A lead of RISE_MV-1 keeps battery mode.
- R3: In supply mode, if `supply_code < batt_code + FALL_MV` (default 50) at a rising edge, battery mode takes effect after that edge. A lead of exactly FALL_MV keeps supply mode.
- R4: While the supply's lead over the battery lies in the band [FALL_MV, RISE_MV), the source does not change, whichever mode it is in.
- R5: `batt_on` is 1 when the rail is fed from the battery and 0 when it is fed from the supply. `backup_mode` always equals `batt_on`.
- R6: In supply mode with `supply_low` = 0, `ce_out_n` equals `ce_in_n` in the same cycle.
- R7: `ce_out_n` is 1 whenever `supply_low` = 1 or the block is in battery mode, regardless of `ce_in_n`.
- R8: In supply mode, `pfail_n` is 0 when `pf_below` = 1 and 1 when `pf_below` = 0.
- R9: In battery mode, `pfail_n` is 0 regardless of `pf_below`.
- R10: The margin comparisons use arithmetic one bit wider than the codes and never wrap. Both codes at 8191 give battery mode. Both codes at 0 give battery mode. A battery code of 8121 with a supply code of 8191 leaves battery mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_code | input | CODE_W | Supply voltage, 1 mV per LSB |
| batt_code | input | CODE_W | Battery voltage, 1 mV per LSB |
| supply_low | input | 1 | 1 when the supply is below the reset threshold |
| ce_in_n | input | 1 | Active-low memory chip-enable from the system |
| pf_below | input | 1 | 1 when the power-fail input is below its 1.3 V reference |
| batt_on | output | 1 | 1 while the rail is fed from the battery |
| ce_out_n | output | 1 | Gated active-low chip-enable to the memory |
| pfail_n | output | 1 | Active-low power-fail warning |
| backup_mode | output | 1 | Backup-mode flag for the rest of the system |

## Verification
The switchover decision is driven through a sequence of supply/battery pairs that step the lead across both margins from each side. Leads of 49, 50, 69 and 70 mV separate a correct threshold from an off-by-one or a swapped comparison. Holding the lead inside the band while in each mode shows that hysteresis keeps the previous state. Codes near full scale and at zero expose any wraparound in the margin sums. The gating outputs are toggled in both modes and with `supply_low` set, which shows that the forced levels override their inputs and that the follow path works only when it should.

// File: rtl/batt_swo_pkg.sv
package batt_swo_pkg;

    // Widest voltage code the compare path supports
    localparam int CODE_W_MAX = 16;
    localparam int EXT_W      = CODE_W_MAX + 1;

    typedef enum logic {
        SRC_SUPPLY = 1'b0,
        SRC_BATT   = 1'b1
    } src_e;

    typedef struct packed {
        logic want_batt;    // lead below the entry margin
        logic want_supply;  // lead at or above the exit margin
    } swo_req_t;

    typedef struct packed {
        logic ce_n;
        logic pfail_n;
    } gate_out_t;

    // True when a >= b + thr, computed without wraparound
    function automatic logic lead_at_least(
        input logic [EXT_W-1:0] a,
        input logic [EXT_W-1:0] b,
        input logic [EXT_W-1:0] thr
    );
        logic [EXT_W:0] rhs;
        rhs = {1'b0, b} + {1'b0, thr};
        return {1'b0, a} >= rhs;
    endfunction

endpackage

// File: rtl/batt_swo_compare.sv
module batt_swo_compare
    import batt_swo_pkg::*;
#(
    parameter int CODE_W  = 13,
    parameter int RISE_MV = 70,
    parameter int FALL_MV = 50
) (
    input  logic [CODE_W-1:0] supply_code,
    input  logic [CODE_W-1:0] batt_code,
    output swo_req_t          req
);
    localparam int PAD_W = EXT_W - CODE_W;
    localparam logic [EXT_W-1:0] RISE_E = EXT_W'(RISE_MV);
    localparam logic [EXT_W-1:0] FALL_E = EXT_W'(FALL_MV);

    logic [EXT_W-1:0] sup_e;
    logic [EXT_W-1:0] bat_e;

    always_comb begin
        sup_e = {{PAD_W{1'b0}}, supply_code};
        bat_e = {{PAD_W{1'b0}}, batt_code};
        req.want_supply = lead_at_least(sup_e, bat_e, RISE_E);
        req.want_batt   = !lead_at_least(sup_e, bat_e, FALL_E);
    end

endmodule

// File: rtl/batt_swo_state.sv
module batt_swo_state
    import batt_swo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  swo_req_t req,
    output src_e     src
);
    src_e src_nxt;

    always_comb begin
        src_nxt = src;
        unique case (src)
            SRC_SUPPLY: if (req.want_batt)   src_nxt = SRC_BATT;
            SRC_BATT:   if (req.want_supply) src_nxt = SRC_SUPPLY;
            default:    src_nxt = SRC_SUPPLY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) src <= SRC_SUPPLY;
        else     src <= src_nxt;
    end

endmodule

// File: rtl/batt_swo_gate.sv
module batt_swo_gate
    import batt_swo_pkg::*;
(
    input  src_e      src,
    input  logic      supply_low,
    input  logic      ce_in_n,
    input  logic      pf_below,
    output gate_out_t gout
);
    logic on_batt;

    always_comb begin
        on_batt      = (src == SRC_BATT);
        // memory writes blocked while power is invalid
        gout.ce_n    = ce_in_n | supply_low | on_batt;
        // comparator ignored in backup, warning held asserted
        gout.pfail_n = !on_batt && !pf_below;
    end

endmodule

// File: rtl/batt_switchover_ctrl.sv
module batt_switchover_ctrl
    import batt_swo_pkg::*;
#(
    parameter int CODE_W  = 13,
    parameter int RISE_MV = 70,
    parameter int FALL_MV = 50
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] supply_code,
    input  logic [CODE_W-1:0] batt_code,
    input  logic              supply_low,
    input  logic              ce_in_n,
    input  logic              pf_below,
    output logic              batt_on,
    output logic              ce_out_n,
    output logic              pfail_n,
    output logic              backup_mode
);
    swo_req_t  req;
    src_e      src;
    gate_out_t gout;

    batt_swo_compare #(
        .CODE_W  (CODE_W),
        .RISE_MV (RISE_MV),
        .FALL_MV (FALL_MV)
    ) i_compare (
        .supply_code (supply_code),
        .batt_code   (batt_code),
        .req         (req)
    );

    batt_swo_state i_state (
        .clk (clk),
        .rst (rst),
        .req (req),
        .src (src)
    );

    batt_swo_gate i_gate (
        .src        (src),
        .supply_low (supply_low),
        .ce_in_n    (ce_in_n),
        .pf_below   (pf_below),
        .gout       (gout)
    );

    assign batt_on     = (src == SRC_BATT);
    assign backup_mode = (src == SRC_BATT);
    assign ce_out_n    = gout.ce_n;
    assign pfail_n     = gout.pfail_n;

endmodule

// File: rtl/batt_switchover_chk.sv
module batt_switchover_chk #(
    parameter int CODE_W  = 13,
    parameter int RISE_MV = 70,
    parameter int FALL_MV = 50
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] supply_code,
    input logic [CODE_W-1:0] batt_code,
    input logic              supply_low,
    input logic              ce_in_n,
    input logic              pf_below,
    input logic              batt_on,
    input logic              ce_out_n,
    input logic              pfail_n,
    input logic              backup_mode
);
    localparam logic [CODE_W+1:0] RISE_X = (CODE_W+2)'(RISE_MV);
    localparam logic [CODE_W+1:0] FALL_X = (CODE_W+2)'(FALL_MV);

    logic [CODE_W+1:0] sup_x;
    logic [CODE_W+1:0] bat_x;
    assign sup_x = {2'b00, supply_code};
    assign bat_x = {2'b00, batt_code};

    a_r1_reset_supply: assert property (@(posedge clk)
        rst |=> (!batt_on && !backup_mode));

    a_r2_leave_backup: assert property (@(posedge clk) disable iff (rst)
        (batt_on && sup_x >= bat_x + RISE_X) |=> !batt_on);

    a_r3_enter_backup: assert property (@(posedge clk) disable iff (rst)
        (!batt_on && sup_x < bat_x + FALL_X) |=> batt_on);

    a_r4_band_hold: assert property (@(posedge clk) disable iff (rst)
        (sup_x >= bat_x + FALL_X && sup_x < bat_x + RISE_X) |=> $stable(batt_on));

    a_r5_flag_match: assert property (@(posedge clk) disable iff (rst)
        backup_mode == batt_on);

    a_r6_ce_follow: assert property (@(posedge clk) disable iff (rst)
        (!batt_on && !supply_low) |-> (ce_out_n == ce_in_n));

    a_r7_ce_forced: assert property (@(posedge clk) disable iff (rst)
        (batt_on || supply_low) |-> ce_out_n);

    a_r8_pfail_follow: assert property (@(posedge clk) disable iff (rst)
        !batt_on |-> (pfail_n == !pf_below));

    a_r9_pfail_forced: assert property (@(posedge clk) disable iff (rst)
        batt_on |-> !pfail_n);

endmodule

bind batt_switchover_ctrl batt_switchover_chk #(
    .CODE_W  (CODE_W),
    .RISE_MV (RISE_MV),
    .FALL_MV (FALL_MV)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .supply_code (supply_code),
    .batt_code   (batt_code),
    .supply_low  (supply_low),
    .ce_in_n     (ce_in_n),
    .pf_below    (pf_below),
    .batt_on     (batt_on),
    .ce_out_n    (ce_out_n),
    .pfail_n     (pfail_n),
    .backup_mode (backup_mode)
);

// File: tb/test_batt_switchover_ctrl.sv
module test_batt_switchover_ctrl;

    localparam int CODE_W = 13;
    localparam int NVEC   = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CODE_W-1:0] supply_code = '0;
    logic [CODE_W-1:0] batt_code   = '0;
    logic              supply_low  = 1'b0;
    logic              ce_in_n     = 1'b1;
    logic              pf_below    = 1'b0;
    logic              batt_on;
    logic              ce_out_n;
    logic              pfail_n;
    logic              backup_mode;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    batt_switchover_ctrl #(.CODE_W(CODE_W)) i_batt_switchover_ctrl (
        .clk         (clk),
        .rst         (rst),
        .supply_code (supply_code),
        .batt_code   (batt_code),
        .supply_low  (supply_low),
        .ce_in_n     (ce_in_n),
        .pf_below    (pf_below),
        .batt_on     (batt_on),
        .ce_out_n    (ce_out_n),
        .pfail_n     (pfail_n),
        .backup_mode (backup_mode)
    );

    // {supply, battery, expected batt_on after the next edge}
    localparam logic [2*CODE_W:0] VEC [NVEC] = '{
        {13'd5000, 13'd3000, 1'b0},  // R4 start in supply mode
        {13'd3060, 13'd3000, 1'b0},  // R4 lead 60, hold supply
        {13'd3050, 13'd3000, 1'b0},  // R3 lead exactly 50, stay
        {13'd3049, 13'd3000, 1'b1},  // R3 lead 49, enter backup
        {13'd3060, 13'd3000, 1'b1},  // R4 lead 60, hold battery
        {13'd3069, 13'd3000, 1'b1},  // R2 lead 69, stay
        {13'd3070, 13'd3000, 1'b0},  // R2 lead 70, leave
        {13'd2000, 13'd3000, 1'b1},  // R3 supply under battery
        {13'd4800, 13'd3000, 1'b0},  // R2 large lead
        {13'd8191, 13'd8191, 1'b1},  // R10 full scale
        {13'd8170, 13'd8100, 1'b0},  // R10 lead 70 near top
        {13'd0,    13'd0,    1'b1},  // R10 both zero
        {13'd70,   13'd0,    1'b0},  // R10 lead 70 from zero
        {13'd8191, 13'd8150, 1'b1},  // R10 lead 41 near top
        {13'd8191, 13'd8122, 1'b1},  // R10 lead 69 near top
        {13'd8191, 13'd8121, 1'b0}   // R10 lead 70, sum at top
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // apply codes at a falling edge, check after the next rising edge
    task automatic step(input logic [CODE_W-1:0] s, input logic [CODE_W-1:0] b);
        @(negedge clk);
        supply_code = s;
        batt_code   = b;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        supply_code = 13'd5000;
        batt_code   = 13'd3000;
        repeat (3) @(negedge clk);
        // R1 reset state, R5 flag matches
        chk("R1 batt_on in reset", batt_on, 1'b0);
        chk("R5 backup_mode in reset", backup_mode, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][2*CODE_W:CODE_W+1], VEC[i][CODE_W:1]);
            chk($sformatf("R2/R3/R4/R10 vector %0d batt_on", i), batt_on, VEC[i][0]);
            chk($sformatf("R5 vector %0d backup_mode", i), backup_mode, VEC[i][0]);
        end

        // supply mode: R6 and R8 follow paths
        step(13'd5000, 13'd3000);
        chk("R5 supply mode", batt_on, 1'b0);
        ce_in_n = 1'b0; #1;
        chk("R6 ce follows low", ce_out_n, 1'b0);
        ce_in_n = 1'b1; #1;
        chk("R6 ce follows high", ce_out_n, 1'b1);
        pf_below = 1'b1; #1;
        chk("R8 pfail asserted", pfail_n, 1'b0);
        pf_below = 1'b0; #1;
        chk("R8 pfail released", pfail_n, 1'b1);

        // R7 supply_low forces chip-enable inactive
        ce_in_n = 1'b0; supply_low = 1'b1; #1;
        chk("R7 ce forced by supply_low", ce_out_n, 1'b1);
        supply_low = 1'b0; #1;
        chk("R6 ce follows after supply_low clears", ce_out_n, 1'b0);

        // battery mode: R7 and R9 overrides
        step(13'd2000, 13'd3000);
        chk("R5 battery mode", batt_on, 1'b1);
        ce_in_n = 1'b0; pf_below = 1'b0; #1;
        chk("R7 ce forced in backup", ce_out_n, 1'b1);
        chk("R9 pfail forced in backup", pfail_n, 1'b0);
        pf_below = 1'b1; #1;
        chk("R9 pfail ignores comparator", pfail_n, 1'b0);
        ce_in_n = 1'b1; #1;
        chk("R7 ce stays inactive", ce_out_n, 1'b1);

        // R1 reset from battery mode
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        chk("R1 reset leaves backup", batt_on, 1'b0);
        chk("R1 backup_mode cleared", backup_mode, 1'b0);
        rst = 1'b0;
        pf_below = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule